// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block works out where fetch goes after each instruction in a core with a single branch delay slot. Each time an instruction steps through, the block receives that instruction's PC, its decoded control-transfer kind, two register operands, a 16-bit word offset and a 26-bit jump index. It then decides whether control transfers and forms the target address. It also reports whether register 31 must receive a return address, and gives that address.

The instruction that follows a branch or jump always executes. A taken transfer therefore does not redirect fetch at once. The target is held in a registered pending slot. The next step still moves fetch sequentially, to the delay-slot instruction, and the step after that moves fetch to the held target. The return address given for linking skips the delay slot: it is the address of the branch plus 8. The fetch PC register starts at a parameterised reset vector.

Top module: `npc_unit`

## Requirements
- R1: While reset is low, `fetch_pc_o` equals `RESET_VEC` and any held redirect is discarded. The first step after reset moves fetch to `pc_i + 4` even if a taken transfer was pending when reset arrived.
- R2: On a cycle with `step_i` high and no redirect pending, `fetch_pc_o` becomes `pc_i + 4` at the next clock edge. With `step_i` low, `fetch_pc_o` and the pending state do not change.
- R3: `br_type_i` encodes the kind as follows: 0 none, 1 branch-if-equal, 2 branch-if-not-equal, 3 branch-if-≤0, 4 branch-if->0, 5 branch-if-<0, 6 branch-if-≥0, 7 branch-if-<0 with link, 8 branch-if-≥0 with link, 9 jump, 10 jump with link, 11 jump to register. Codes 12 to 15 act as none. Kind 1 is taken when `rs_i == rt_i`, and kind 2 is taken when they differ.
- R4: Kinds 3 to 8 compare `rs_i` against zero as a two's-complement value and ignore `rt_i`.
- R5: The target of kinds 1 to 8 is `pc_i + 4 + (sign-extended offset_i × 4)`.
- R6: The target of kinds 9 and 10 is `{pc_i[31:28], jidx_i, 2'b00}`, and both are always taken.
- R7: The target of kind 11 is `rs_i`, and it is always taken.
- R8: After a step carrying a taken transfer, `fetch_pc_o` becomes the branch PC + 4 (the delay slot). The next step then moves `fetch_pc_o` to the held target, whatever `pc_i` is on that step.
- R9: During a step of kind 7, 8 or 10, `link_we_o` is high, whether or not the transfer is taken, and `link_data_o` equals `pc_i + 8`. For every other kind, and whenever `step_i` is low, `link_we_o` is low.
- R10: A step carrying a branch whose condition fails, or a non-transfer kind, leaves no redirect. Fetch continues sequentially through and after the delay slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | An instruction is retiring this cycle |
| pc_i | input | 32 | PC of the retiring instruction |
| br_type_i | input | 4 | Decoded control-transfer kind (see R3) |
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand |
| offset_i | input | 16 | Signed word offset for conditional branches |
| jidx_i | input | 26 | Jump index for region jumps |
| fetch_pc_o | output | 32 | Registered address of the next instruction to fetch |
| link_we_o | output | 1 | Write return address into register 31 |
| link_data_o | output | 32 | Return address, branch PC + 8 |

## Verification
The hardest situation to reach is a taken transfer whose redirect is still held when something else happens: reset arrives, or the delay-slot step carries a PC unrelated to the target. The bench drives each transfer as two steps. The first is the branch itself. The second is a plain instruction at the branch PC + 4, so that fetch is seen passing through the delay slot before it lands on the target. Reset is also pulled low between the two steps. The sweeps cover boundary operands around zero and the signed extremes, offsets at both ends of their range, and jump indices with different upper PC bits.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    BR_NONE  = 4'd0,
    BR_EQ    = 4'd1,
    BR_NE    = 4'd2,
    BR_LEZ   = 4'd3,
    BR_GTZ   = 4'd4,
    BR_LTZ   = 4'd5,
    BR_GEZ   = 4'd6,
    BR_LTZAL = 4'd7,
    BR_GEZAL = 4'd8,
    BR_J     = 4'd9,
    BR_JAL   = 4'd10,
    BR_JR    = 4'd11
  } br_kind_e;

  typedef enum logic [1:0] {
    TGT_REL    = 2'd0,
    TGT_REGION = 2'd1,
    TGT_REG    = 2'd2
  } tgt_src_e;

  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  br_kind_e     kind_i,
  input  logic [W-1:0] rs_i,
  input  logic [W-1:0] rt_i,
  output logic         taken_o,
  output logic         link_o,
  output tgt_src_e     src_o
);

  logic rs_neg, rs_zero, ops_eq;

  assign rs_neg  = rs_i[W-1];
  assign rs_zero = (rs_i == '0);
  assign ops_eq  = (rs_i == rt_i);

  always_comb begin
    taken_o = 1'b0;
    link_o  = 1'b0;
    src_o   = TGT_REL;
    unique case (kind_i)
      BR_EQ:    taken_o = ops_eq;
      BR_NE:    taken_o = !ops_eq;
      BR_LEZ:   taken_o = rs_neg || rs_zero;
      BR_GTZ:   taken_o = !rs_neg && !rs_zero;
      BR_LTZ:   taken_o = rs_neg;
      BR_GEZ:   taken_o = !rs_neg;
      BR_LTZAL: begin taken_o = rs_neg;  link_o = 1'b1; end
      BR_GEZAL: begin taken_o = !rs_neg; link_o = 1'b1; end
      BR_J:     begin taken_o = 1'b1; src_o = TGT_REGION; end
      BR_JAL:   begin taken_o = 1'b1; link_o = 1'b1; src_o = TGT_REGION; end
      BR_JR:    begin taken_o = 1'b1; src_o = TGT_REG; end
      default:  ;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned IDX_W = 26
) (
  input  logic [W-1:0]     pc_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [IDX_W-1:0] jidx_i,
  input  logic [W-1:0]     rs_i,
  input  tgt_src_e         src_i,
  output logic [W-1:0]     seq_o,
  output logic [W-1:0]     link_val_o,
  output logic [W-1:0]     tgt_o
);

  localparam int unsigned EXT_W    = W - OFF_W - WORD_SHIFT;
  localparam int unsigned REGION_W = W - IDX_W - WORD_SHIFT;

  logic [W-1:0] disp, rel_tgt, region_tgt;

  assign seq_o      = pc_i + W'(INSN_BYTES);
  assign link_val_o = pc_i + W'(2 * INSN_BYTES);

  // word offset -> byte displacement
  assign disp       = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, {WORD_SHIFT{1'b0}}};
  assign rel_tgt    = seq_o + disp;
  assign region_tgt = {pc_i[W-1 -: REGION_W], jidx_i, {WORD_SHIFT{1'b0}}};

  always_comb begin
    unique case (src_i)
      TGT_REGION: tgt_o = region_tgt;
      TGT_REG:    tgt_o = rs_i;
      default:    tgt_o = rel_tgt;
    endcase
  end

endmodule

// File: rtl/npc_hold.sv
module npc_hold #(
  parameter int unsigned  W         = 32,
  parameter logic [W-1:0] RESET_VEC = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         taken_i,
  input  logic [W-1:0] tgt_i,
  input  logic [W-1:0] seq_i,
  output logic [W-1:0] fetch_pc_o,
  output logic         pend_o,
  output logic [W-1:0] pend_tgt_o
);

  logic [W-1:0] fetch_q, tgt_q;
  logic         pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q <= RESET_VEC;
      pend_q  <= 1'b0;
      tgt_q   <= '0;
    end else if (step_i) begin
      // a held redirect lands one step after the delay slot
      fetch_q <= pend_q ? tgt_q : seq_i;
      pend_q  <= taken_i;
      if (taken_i) tgt_q <= tgt_i;
    end
  end

  assign fetch_pc_o = fetch_q;
  assign pend_o     = pend_q;
  assign pend_tgt_o = tgt_q;

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned  W         = 32,
  parameter int unsigned  OFF_W     = 16,
  parameter int unsigned  IDX_W     = 26,
  parameter logic [W-1:0] RESET_VEC = 32'hBFC0_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [W-1:0]     pc_i,
  input  logic [3:0]       br_type_i,
  input  logic [W-1:0]     rs_i,
  input  logic [W-1:0]     rt_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [IDX_W-1:0] jidx_i,
  output logic [W-1:0]     fetch_pc_o,
  output logic             link_we_o,
  output logic [W-1:0]     link_data_o
);

  br_kind_e     kind;
  tgt_src_e     src;
  logic         taken, link;
  logic [W-1:0] seq, link_val, tgt;
  logic         pend;
  logic [W-1:0] pend_tgt;

  assign kind = br_kind_e'(br_type_i);

  npc_cond #(.W(W)) u_cond (
    .kind_i  (kind),
    .rs_i    (rs_i),
    .rt_i    (rt_i),
    .taken_o (taken),
    .link_o  (link),
    .src_o   (src)
  );

  npc_target #(.W(W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_target (
    .pc_i       (pc_i),
    .offset_i   (offset_i),
    .jidx_i     (jidx_i),
    .rs_i       (rs_i),
    .src_i      (src),
    .seq_o      (seq),
    .link_val_o (link_val),
    .tgt_o      (tgt)
  );

  npc_hold #(.W(W), .RESET_VEC(RESET_VEC)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step_i),
    .taken_i    (taken),
    .tgt_i      (tgt),
    .seq_i      (seq),
    .fetch_pc_o (fetch_pc_o),
    .pend_o     (pend),
    .pend_tgt_o (pend_tgt)
  );

  assign link_we_o   = step_i && link;
  assign link_data_o = link_val;

endmodule

// File: rtl/npc_unit_sva.sv
module npc_unit_sva #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         step_i,
  input logic [W-1:0] pc_i,
  input logic [3:0]   br_type_i,
  input logic [W-1:0] rs_i,
  input logic [W-1:0] fetch_pc_o,
  input logic         link_we_o,
  input logic [W-1:0] link_data_o,
  input logic         pend,
  input logic [W-1:0] pend_tgt
);

  AST_SEQ_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !pend |=> fetch_pc_o == $past(pc_i) + W'(4)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(fetch_pc_o) && $stable(pend)); // R2

  AST_REDIRECT_AFTER_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && pend |=> fetch_pc_o == $past(pend_tgt)); // R8

  AST_JUMP_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && br_type_i == 4'd9 |=> pend); // R6

  AST_JR_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && br_type_i == 4'd11 |=> pend && pend_tgt == $past(rs_i)); // R7

  AST_LINK_ONLY_ON_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> step_i); // R9

  AST_JAL_LINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && br_type_i == 4'd10 |-> link_we_o && link_data_o == pc_i + W'(8)); // R9

  AST_NONE_NO_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && br_type_i == 4'd0 |=> !pend); // R10

endmodule

bind npc_unit npc_unit_sva #(.W(W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .step_i      (step_i),
  .pc_i        (pc_i),
  .br_type_i   (br_type_i),
  .rs_i        (rs_i),
  .fetch_pc_o  (fetch_pc_o),
  .link_we_o   (link_we_o),
  .link_data_o (link_data_o),
  .pend        (pend),
  .pend_tgt    (pend_tgt)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;

  localparam logic [31:0] RVEC = 32'hBFC0_0000;
  localparam logic [3:0] K_NONE = 4'd0, K_EQ = 4'd1, K_NE = 4'd2, K_LEZ = 4'd3,
                         K_GTZ = 4'd4, K_LTZ = 4'd5, K_GEZ = 4'd6, K_LTZAL = 4'd7,
                         K_GEZAL = 4'd8, K_J = 4'd9, K_JAL = 4'd10, K_JR = 4'd11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [31:0] pc = '0, rs = '0, rt = '0;
  logic [3:0]  ty = '0;
  logic [15:0] off = '0;
  logic [25:0] jx = '0;
  logic [31:0] fetch, ldata;
  logic        lwe;

  int checks = 0;
  int errs   = 0;

  always #2 clk = ~clk;

  npc_unit u_npc_unit (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .pc_i(pc), .br_type_i(ty),
    .rs_i(rs), .rt_i(rt), .offset_i(off), .jidx_i(jx),
    .fetch_pc_o(fetch), .link_we_o(lwe), .link_data_o(ldata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit exp_taken(input logic [3:0] t, input logic [31:0] a, input logic [31:0] b);
    case (t)
      K_EQ:            return a == b;
      K_NE:            return a != b;
      K_LEZ:           return $signed(a) <= 0;
      K_GTZ:           return $signed(a) > 0;
      K_LTZ, K_LTZAL:  return $signed(a) < 0;
      K_GEZ, K_GEZAL:  return $signed(a) >= 0;
      K_J, K_JAL, K_JR: return 1'b1;
      default:         return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_tgt(input logic [3:0] t, input logic [31:0] p,
                                          input logic [31:0] a, input logic [15:0] o,
                                          input logic [25:0] j);
    if (t == K_J || t == K_JAL) return (p & 32'hF000_0000) | (32'(j) * 4);
    if (t == K_JR) return a;
    return p + 32'd4 + 32'($signed(o)) * 32'd4;
  endfunction

  // branch step, then a plain step at the delay slot
  task automatic run_case(input logic [3:0] t, input logic [31:0] p, input logic [31:0] a,
                          input logic [31:0] b, input logic [15:0] o, input logic [25:0] j,
                          input string rq);
    bit tk, lk;
    logic [31:0] tg;
    tk = exp_taken(t, a, b);
    tg = exp_tgt(t, p, a, o, j);
    lk = (t == K_JAL) || (t == K_LTZAL) || (t == K_GEZAL);
    @(negedge clk);
    step = 1'b1; ty = t; pc = p; rs = a; rt = b; off = o; jx = j;
    #1;
    chk(lwe == lk, "R9 link enable", 32'(lwe), 32'(lk));
    if (lk) chk(ldata == p + 32'd8, "R9 link value", ldata, p + 32'd8);
    @(negedge clk);
    chk(fetch == p + 32'd4, "R8 delay slot fetch", fetch, p + 32'd4);
    ty = K_NONE; pc = p + 32'd4;
    @(negedge clk);
    if (tk) chk(fetch == tg, rq, fetch, tg);
    else    chk(fetch == p + 32'd8, "R10 not taken", fetch, p + 32'd8);
    step = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL R2 watchdog: actual >= %0d cycles expected fewer", 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    logic [31:0] vals [5];
    logic [15:0] offs [5];
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000;
    offs[0] = 16'h0; offs[1] = 16'h1; offs[2] = 16'hFFFF;
    offs[3] = 16'h7FFF; offs[4] = 16'h8000;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(fetch == RVEC, "R1 reset vector", fetch, RVEC);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch == RVEC, "R1 idle after reset", fetch, RVEC);

    // R2 sequential step and idle hold
    step = 1'b1; pc = 32'h0000_1000; ty = K_NONE;
    @(negedge clk);
    chk(fetch == 32'h0000_1004, "R2 sequential", fetch, 32'h0000_1004);
    step = 1'b0;
    repeat (2) @(negedge clk);
    chk(fetch == 32'h0000_1004, "R2 hold when idle", fetch, 32'h0000_1004);

    // R3 equal / not-equal over operand grid
    for (int i = 0; i < 5; i++)
      for (int k = 0; k < 5; k++) begin
        run_case(K_EQ, 32'h0040_0100, vals[i], vals[k], 16'h0010, '0, "R3 beq target");
        run_case(K_NE, 32'h0040_0200, vals[i], vals[k], 16'hFFF0, '0, "R3 bne target");
      end

    // R4 compare against zero, rt irrelevant
    for (int t = 3; t <= 8; t++)
      for (int i = 0; i < 5; i++)
        run_case(4'(t), 32'h0040_0300, vals[i], vals[(i + 2) % 5], 16'h0020, '0, "R4 zero compare");

    // R5 offset extremes
    for (int i = 0; i < 5; i++) begin
      run_case(K_EQ,  32'h1000_8000, 32'h5, 32'h5, offs[i], '0, "R5 offset target");
      run_case(K_GEZ, 32'h8000_0000, 32'h0, 32'h0, offs[i], '0, "R5 offset target");
    end

    // R6 region jumps across upper PC bits
    for (int h = 0; h < 16; h += 5)
      for (int i = 0; i < 3; i++) begin
        run_case(K_J,   {4'(h), 28'h0ABC_DE0}, '0, '0, '0, (i == 0) ? 26'h0 : (i == 1) ? 26'h3FF_FFFF : 26'h123_4567, "R6 jump target");
        run_case(K_JAL, {4'(h), 28'h0000_040}, '0, '0, '0, (i == 0) ? 26'h1 : (i == 1) ? 26'h200_0000 : 26'h0F0_F0F0, "R6 jal target");
      end

    // R7 register jump
    for (int i = 0; i < 5; i++)
      run_case(K_JR, 32'h0040_0400, vals[i] & 32'hFFFF_FFFC, '0, '0, '0, "R7 jr target");

    // R10 unused codes act as none
    for (int t = 12; t < 16; t++)
      run_case(4'(t), 32'h0040_0500, '0, '0, 16'h0100, 26'h100, "R10 unused code");

    // R2 hold after a taken branch then idle before slot step
    @(negedge clk);
    step = 1'b1; ty = K_J; pc = 32'h0040_0600; jx = 26'h0000_200;
    @(negedge clk);
    step = 1'b0;
    repeat (2) @(negedge clk);
    chk(fetch == 32'h0040_0604, "R2 hold with pending", fetch, 32'h0040_0604);
    step = 1'b1; ty = K_NONE; pc = 32'h0040_0604;
    @(negedge clk);
    chk(fetch == 32'h0000_0800, "R8 redirect after idle", fetch, 32'h0000_0800);
    step = 1'b0;

    // R1 reset discards a pending redirect
    @(negedge clk);
    step = 1'b1; ty = K_JAL; pc = 32'h0040_0700; jx = 26'h0000_300;
    @(negedge clk);
    step = 1'b0; rst_n = 1'b0;
    #1;
    chk(fetch == RVEC, "R1 reset while pending", fetch, RVEC);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step = 1'b1; ty = K_NONE; pc = 32'h0000_2000;
    @(negedge clk);
    chk(fetch == 32'h0000_2004, "R1 pending dropped", fetch, 32'h0000_2004);
    step = 1'b0;
    #1;
    chk(lwe == 1'b0, "R9 no link when idle", 32'(lwe), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule